// File: doc/BRIEF.md
# Parity-Chain Two-Bus Hit Arbiter

This block gathers hits from a strip of readout cells, laid out as 22 columns of 2 cells, and reports up to two hit addresses in each slow-clock period on two shared 6-bit address lanes. Each cell first chooses its hit source. The source is the normal comparator or the time-walk-compensated comparator, and a gated digital-inject line is ORed in after that choice. The cell then registers the source and turns a rising edge into a hit that lasts one clock period.

A single parity bit ripples through the cells in ascending cell order. A hit cell that sees parity 0 arriving puts its Gray-coded address on lane 1. A hit cell that sees parity 1 arriving uses lane 2. Each cell passes on the incoming parity XOR its own hit. Each lane is the OR of every cell that drives it, so three or more hits corrupt the addresses in a defined way. The final parity, the two lane addresses and the two lane-used flags are registered together and leave the block as one report per period.

Top module: `sra_hit_arbiter`

## Requirements
- R1: While reset is high, and in the period after it is released, all outputs are 0.
- R2: Cell number equals column×2 + row. The address a cell drives is its cell number in 6-bit reflected Gray code (n XOR n>>1), so cell 43 drives 6'b111110.
- R3: A period with no hits reports parity 0, both flags 0 and both lanes 6'b000000.
- R4: A single hit reports parity 1, lane-1 flag 1 and lane-2 flag 0. Lane 1 carries that cell's address and lane 2 reads 0.
- R5: For two hits, the lower cell number goes on lane 1 and the higher on lane 2. Both flags are 1 and parity is 0.
- R6: For three hits, parity is 1 and both flags are 1. Lane 1 carries the OR of the addresses of the lowest and highest cells, and lane 2 carries the middle cell's address.
- R7: In general, hits alternate between lane 1 and lane 2 in ascending cell order. Each lane is the OR of its addresses, and parity is the hit count modulo 2, so four hits or all 44 hits give parity 0.
- R8: With src_sel 0 the normal comparator feeds the readout. With src_sel 1 the time-walk comparator feeds it. Edges on the comparator that is not selected produce no hit.
- R9: A rising edge on dig_inj produces a hit only in cells whose inj_en bit is 1.
- R10: A source rising edge that falls between clock edges n and n+1 appears on the outputs from edge n+2 until edge n+3. It is reported in exactly that one period.
- R11: Only rising edges count. A source held high for several periods gives one report, and a falling edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow readout clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | 0 selects normal comparators, 1 selects time-walk comparators |
| comp_norm | input | 44 | Normal comparator outputs, indexed by cell number |
| comp_tw | input | 44 | Time-walk comparator outputs, indexed by cell number |
| inj_en | input | 44 | Per-cell digital-inject enable |
| dig_inj | input | 1 | Shared digital-inject pulse |
| bus1_addr | output | 6 | Lane-1 address (OR of its drivers) |
| bus2_addr | output | 6 | Lane-2 address (OR of its drivers) |
| bus1_hit | output | 1 | Lane 1 carries at least one hit |
| bus2_hit | output | 1 | Lane 2 carries at least one hit |
| parity_out | output | 1 | Final chain parity (hit count modulo 2) |

## Verification
The assertions assume that the cell inputs are stable around the sampling edge. They also assume that src_sel changes only while both comparator sets are low, because a change with a comparator high would look like an edge. The stimulus respects both assumptions. It changes all inputs at the falling clock edge, sets src_sel only when every source is low, and returns every source to 0 before the next event. The gap between events is long enough that a falling edge never overlaps a new rising edge in the same cell.

// File: rtl/sra_pkg.sv
package sra_pkg;

    // Default geometry of the cell strip
    localparam int NCOL_DEF = 22;
    localparam int NROW_DEF = 2;

    // Which comparator feeds the readout
    typedef enum logic {
        SRC_NORMAL   = 1'b0,
        SRC_TIMEWALK = 1'b1
    } src_sel_e;

    // Reflected binary Gray code of a cell number
    function automatic int gray_code(input int n);
        return n ^ (n >> 1);
    endfunction

    // Cell number from column and row position
    function automatic int cell_number(input int col, input int row, input int nrow);
        return col * nrow + row;
    endfunction

endpackage

// File: rtl/sra_cell_front.sv
module sra_cell_front
    import sra_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e src_sel,
    input  logic     comp_norm,
    input  logic     comp_tw,
    input  logic     inj_en,
    input  logic     dig_inj,
    output logic     hit
);

    logic src;
    logic cap_q;
    logic prev_q;

    // Source choice, with digital inject joining after the comparator
    always_comb begin
        case (src_sel)
            SRC_TIMEWALK: src = comp_tw;
            default:      src = comp_norm;
        endcase
        src = src | (inj_en & dig_inj);
    end

    // Capture the level, keep the previous level for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cap_q  <= src;
            prev_q <= cap_q;
        end
    end

    // A hit lasts exactly one period
    assign hit = cap_q & ~prev_q;

endmodule

// File: rtl/sra_parity_chain.sv
module sra_parity_chain
    import sra_pkg::*;
#(
    parameter int NCELL = 44,
    parameter int AW    = 6
) (
    input  logic [NCELL-1:0] cell_hit,
    output logic [AW-1:0]    lane1_addr,
    output logic [AW-1:0]    lane2_addr,
    output logic             lane1_used,
    output logic             lane2_used,
    output logic             parity
);

    logic [NCELL:0]  par;
    logic [NCELL:0]  used1;
    logic [NCELL:0]  used2;
    logic [AW-1:0]   acc1 [NCELL+1];
    logic [AW-1:0]   acc2 [NCELL+1];

    assign par[0]   = 1'b0;
    assign used1[0] = 1'b0;
    assign used2[0] = 1'b0;
    assign acc1[0]  = '0;
    assign acc2[0]  = '0;

    for (genvar i = 0; i < NCELL; i++) begin : g_link
        localparam int            GI   = gray_code(i);
        localparam logic [AW-1:0] ADDR = GI[AW-1:0];

        logic to1;
        logic to2;

        // Incoming parity picks the lane
        assign to1 = cell_hit[i] & ~par[i];
        assign to2 = cell_hit[i] &  par[i];

        assign par[i+1]   = par[i] ^ cell_hit[i];
        assign used1[i+1] = used1[i] | to1;
        assign used2[i+1] = used2[i] | to2;
        assign acc1[i+1]  = acc1[i] | (to1 ? ADDR : '0);
        assign acc2[i+1]  = acc2[i] | (to2 ? ADDR : '0);
    end

    assign lane1_addr = acc1[NCELL];
    assign lane2_addr = acc2[NCELL];
    assign lane1_used = used1[NCELL];
    assign lane2_used = used2[NCELL];
    assign parity     = par[NCELL];

endmodule

// File: rtl/sra_hit_arbiter.sv
module sra_hit_arbiter
    import sra_pkg::*;
#(
    parameter int NCOL = NCOL_DEF,
    parameter int NROW = NROW_DEF,
    localparam int NCELL = NCOL * NROW,
    localparam int AW    = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_sel,
    input  logic [NCELL-1:0] comp_norm,
    input  logic [NCELL-1:0] comp_tw,
    input  logic [NCELL-1:0] inj_en,
    input  logic             dig_inj,
    output logic [AW-1:0]    bus1_addr,
    output logic [AW-1:0]    bus2_addr,
    output logic             bus1_hit,
    output logic             bus2_hit,
    output logic             parity_out
);

    src_sel_e         sel;
    logic [NCELL-1:0] cell_hit;
    logic [AW-1:0]    l1_addr;
    logic [AW-1:0]    l2_addr;
    logic             l1_used;
    logic             l2_used;
    logic             chain_par;

    assign sel = src_sel_e'(src_sel);

    // One front end per cell, placed by column and row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < NROW; r++) begin : g_row
            localparam int IDX = cell_number(c, r, NROW);
            sra_cell_front u_front (
                .clk       (clk),
                .rst       (rst),
                .src_sel   (sel),
                .comp_norm (comp_norm[IDX]),
                .comp_tw   (comp_tw[IDX]),
                .inj_en    (inj_en[IDX]),
                .dig_inj   (dig_inj),
                .hit       (cell_hit[IDX])
            );
        end
    end

    sra_parity_chain #(
        .NCELL (NCELL),
        .AW    (AW)
    ) u_chain (
        .cell_hit   (cell_hit),
        .lane1_addr (l1_addr),
        .lane2_addr (l2_addr),
        .lane1_used (l1_used),
        .lane2_used (l2_used),
        .parity     (chain_par)
    );

    // Report register: one coherent word per period
    always_ff @(posedge clk) begin
        if (rst) begin
            bus1_addr  <= '0;
            bus2_addr  <= '0;
            bus1_hit   <= 1'b0;
            bus2_hit   <= 1'b0;
            parity_out <= 1'b0;
        end else begin
            bus1_addr  <= l1_addr;
            bus2_addr  <= l2_addr;
            bus1_hit   <= l1_used;
            bus2_hit   <= l2_used;
            parity_out <= chain_par;
        end
    end

endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
    parameter int NCELL = 44,
    parameter int AW    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [NCELL-1:0] cell_hit,
    input logic [AW-1:0]    bus1_addr,
    input logic [AW-1:0]    bus2_addr,
    input logic             bus1_hit,
    input logic             bus2_hit,
    input logic             parity_out
);

    AST_LANE2_AFTER_LANE1: assert property (@(posedge clk) disable iff (rst) bus2_hit |-> bus1_hit); // R7
    AST_LANE1_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !bus1_hit |-> bus1_addr == '0); // R3
    AST_LANE2_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !bus2_hit |-> bus2_addr == '0); // R4
    AST_NO_HIT_NO_PARITY: assert property (@(posedge clk) disable iff (rst) !bus1_hit |-> !parity_out); // R3
    AST_SINGLE_ODD: assert property (@(posedge clk) disable iff (rst) (bus1_hit && !bus2_hit) |-> parity_out); // R4
    AST_PARITY_COUNT: assert property (@(posedge clk) disable iff (rst) parity_out == $past(^cell_hit)); // R7
    AST_HIT_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst) (cell_hit & $past(cell_hit)) == '0); // R11
    AST_REPORT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (rst) (|cell_hit) |=> bus1_hit); // R10

endmodule

bind sra_hit_arbiter sra_checker #(
    .NCELL (NCELL),
    .AW    (AW)
) u_sra_checker (
    .clk        (clk),
    .rst        (rst),
    .cell_hit   (cell_hit),
    .bus1_addr  (bus1_addr),
    .bus2_addr  (bus2_addr),
    .bus1_hit   (bus1_hit),
    .bus2_hit   (bus2_hit),
    .parity_out (parity_out)
);

// File: tb/sra_hit_arbiter_bench.sv
module sra_hit_arbiter_bench;

    localparam int NCELL = 44;
    localparam int AW    = 6;

    typedef struct {
        int            cyc;
        logic [AW-1:0] b1;
        logic [AW-1:0] b2;
        logic          h1;
        logic          h2;
        logic          p;
        string         req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             src_sel = 1'b0;
    logic [NCELL-1:0] comp_norm = '0;
    logic [NCELL-1:0] comp_tw = '0;
    logic [NCELL-1:0] inj_en = '0;
    logic             dig_inj = 1'b0;
    logic [AW-1:0]    bus1_addr;
    logic [AW-1:0]    bus2_addr;
    logic             bus1_hit;
    logic             bus2_hit;
    logic             parity_out;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t q[$];

    sra_hit_arbiter u_sra_hit_arbiter (
        .clk        (clk),
        .rst        (rst),
        .src_sel    (src_sel),
        .comp_norm  (comp_norm),
        .comp_tw    (comp_tw),
        .inj_en     (inj_en),
        .dig_inj    (dig_inj),
        .bus1_addr  (bus1_addr),
        .bus2_addr  (bus2_addr),
        .bus1_hit   (bus1_hit),
        .bus2_hit   (bus2_hit),
        .parity_out (parity_out)
    );

    always #4ns clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [AW-1:0] gray6(input int n);
        logic [AW-1:0] v;
        v = n[AW-1:0];
        return v ^ (v >> 1);
    endfunction

    // Expected report from the set of cells that saw a rising edge (R2, R7)
    function automatic exp_t expect_of(input logic [NCELL-1:0] m, input int at, input string req);
        exp_t e;
        logic side;
        e.cyc = at; e.b1 = '0; e.b2 = '0; e.h1 = 1'b0; e.h2 = 1'b0; e.req = req;
        side = 1'b0;
        for (int i = 0; i < NCELL; i++) begin
            if (m[i]) begin
                if (!side) begin e.b1 |= gray6(i); e.h1 = 1'b1; end
                else       begin e.b2 |= gray6(i); e.h2 = 1'b1; end
                side = ~side;
            end
        end
        e.p = side;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (bus1_addr !== e.b1 || bus2_addr !== e.b2 || bus1_hit !== e.h1 ||
            bus2_hit !== e.h2 || parity_out !== e.p) begin
            errors++;
            $display("FAIL %s cyc %0d actual b1=%b b2=%b h1=%b h2=%b p=%b expected b1=%b b2=%b h1=%b h2=%b p=%b",
                     e.req, cyc, bus1_addr, bus2_addr, bus1_hit, bus2_hit, parity_out,
                     e.b1, e.b2, e.h1, e.h2, e.p);
        end
    endtask

    // Monitor: scheduled reports are popped, every other period must be idle (R10, R3)
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                compare(q.pop_front());
            end else begin
                compare(expect_of('0, cyc, "R10_idle"));
            end
        end
    end

    // Driver: one event, then sources return low and the bench waits
    task automatic run_bin(input logic sel, input logic [NCELL-1:0] norm, input logic [NCELL-1:0] tw,
                           input logic [NCELL-1:0] ien, input logic inj, input int hold,
                           input logic [NCELL-1:0] hits, input string req);
        @(negedge clk);
        src_sel = sel;
        @(negedge clk);
        comp_norm = norm; comp_tw = tw; inj_en = ien; dig_inj = inj;
        q.push_back(expect_of(hits, cyc + 2, req));
        repeat (hold) @(negedge clk);
        comp_norm = '0; comp_tw = '0; inj_en = '0; dig_inj = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [NCELL-1:0] bit_at(input int i);
        logic [NCELL-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        logic [NCELL-1:0] m;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        compare(expect_of('0, cyc, "R1"));
        rst = 1'b0;
        @(negedge clk);
        compare(expect_of('0, cyc, "R1_after"));
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // R3: no edges at all
        run_bin(1'b0, '0, '0, '0, 1'b0, 1, '0, "R3");
        // R4 and R2: single hits at both ends of the strip
        run_bin(1'b0, bit_at(0), '0, '0, 1'b0, 1, bit_at(0), "R4_cell0");
        run_bin(1'b0, bit_at(43), '0, '0, 1'b0, 1, bit_at(43), "R2_cell43");
        // R2: column 7 row 1 is cell 15, Gray 6'b001000
        run_bin(1'b0, bit_at(15), '0, '0, 1'b0, 1, bit_at(15), "R2_col7row1");
        // R5: two hits
        m = bit_at(5) | bit_at(30);
        run_bin(1'b0, m, '0, '0, 1'b0, 1, m, "R5");
        // R6: three hits, lane 1 = g1|g4
        m = bit_at(1) | bit_at(2) | bit_at(4);
        run_bin(1'b0, m, '0, '0, 1'b0, 1, m, "R6");
        // R7: four hits and all cells
        m = bit_at(3) | bit_at(10) | bit_at(20) | bit_at(40);
        run_bin(1'b0, m, '0, '0, 1'b0, 1, m, "R7_four");
        run_bin(1'b0, '1, '0, '0, 1'b0, 1, '1, "R7_all");
        // R8: time-walk selected, normal edges ignored, and the reverse
        m = bit_at(9) | bit_at(22);
        run_bin(1'b1, bit_at(2), m, '0, 1'b0, 1, m, "R8_tw");
        run_bin(1'b1, m, '0, '0, 1'b0, 1, '0, "R8_norm_ignored");
        run_bin(1'b0, bit_at(11), m, '0, 1'b0, 1, bit_at(11), "R8_tw_ignored");
        // R9: digital inject gated per cell
        m = bit_at(7) | bit_at(36);
        run_bin(1'b0, '0, '0, m, 1'b1, 1, m, "R9_enabled");
        run_bin(1'b0, '0, '0, '0, 1'b1, 1, '0, "R9_disabled");
        // R11: held high for several periods gives one report
        run_bin(1'b0, bit_at(25), '0, '0, 1'b0, 5, bit_at(25), "R11_hold");

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending reports actual %0d expected 0", q.size());
        end
        finish_run();
    end

    initial begin
        #(8ns * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

endmodule